// File: doc/BRIEF.md
# Switchable-Polynomial CRC Accelerator with Bus Snooping

This block is a small register-mapped CRC engine that sits on a simple byte-addressed register bus. Software chooses one of five generator polynomials and a bit order. It then pushes data into an input register, either one byte or one 32-bit word at a time. Every write is folded into a running remainder, and software reads the remainder back as a 32-, 16- or 8-bit value. The remainder is cleared to zero only by a clear command or by reset. No initial value and no final XOR are applied.

The block can also take its data without any explicit input write. When snooping is armed, it watches bus transfers aimed at other targets. A transfer of the chosen direction (read or write) whose low 14 address bits equal a programmed snoop address has its data byte fed to the engine, exactly as a direct byte write would be. For snooped reads, the byte comes from the read-return lane that the addressed target drives onto the shared bus.

Top module: `crc_snoop_unit`

## Requirements
- R1: The polynomial field is config register (offset 0) bits [2:0]. The codes are: 1 = CRC-8 (0x07), 2 = CRC-16 (0x8005), 3 = CRC-CCITT (0x1021), 4 = CRC-32 (0x04C11DB7) and 5 = CRC-32C (0x1EDC6F41). With code 0, 6 or 7, data writes leave the remainder unchanged.
- R2: Config bit 6 selects the bit order. 0 = LSB-first, using the reflected polynomial with data bit 0 first. 1 = MSB-first, using the normal polynomial with data bit 7 first.
- R3: Writing config bit 7 as 1 clears the remainder to zero. Writing it as 0 leaves the remainder alone. Bit 7 always reads 0, and the other config bits read back as written.
- R4: The snoop control register (offset 1) has bit 7 = snoop enable and bit 6 = direction (1 = writes, 0 = reads). It reads back as written, with the other bits reading 0.
- R5: A write to offset 4 with size code 2 (word) folds four bytes, least significant first. Any other size code folds only byte [7:0]. The new remainder is readable in the cycle after the write.
- R6: A read of offset 8 returns the remainder. Size code 0 gives bits [7:0] and size code 1 gives bits [15:0], each zero-extended. Size code 2 gives all 32 bits.
- R7: The snoop address register (offset 12) holds 14 bits in [13:0]. Bits above 13 are dropped on write and read as 0.
- R8: After reset, every register and the remainder read as zero.
- R9: Snooping applies only to a transfer that meets all of these conditions: busSel is low, snooping is enabled, the direction matches, and busAddr[13:0] equals the snoop address. Such a transfer folds one byte: busWdata[7:0] for a write, or busRdIn for a read. All other transfers leave the remainder unchanged.
- R10: With CRC-8 selected, output bits [31:8] read as zero. With either 16-bit polynomial selected, bits [31:16] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A transfer is on the bus this cycle |
| busSel | input | 1 | The transfer targets this block's registers |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| busAddr | input | 16 | Byte address (low 4 bits are the register offset when selected) |
| busWdata | input | 32 | Write data, right-aligned |
| busRdIn | input | 8 | Byte returned by another target on a bus read (snoop source) |
| busRdata | output | 32 | Read data for selected reads, zero otherwise |

## Verification
Register reads are combinational, so the bench samples busRdata one nanosecond after it drives a read at the falling edge. Every write, clear or snooped transfer takes effect at the next rising edge. Each result is therefore due in the cycle after its transfer, and the bench reads it back in the following bus cycle. The bench model updates its expected remainder at the moment it issues each fold. Every readback is compared against that model in the exact cycle the result becomes visible.

// File: rtl/crc_snoop_pkg.sv
package crc_snoop_pkg;

  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int LANES   = WORD_W / LANE_W;
  localparam int OFF_W   = 4;

  localparam logic [OFF_W-1:0] OFF_CFG  = 4'd0;
  localparam logic [OFF_W-1:0] OFF_SNP  = 4'd1;
  localparam logic [OFF_W-1:0] OFF_DIN  = 4'd4;
  localparam logic [OFF_W-1:0] OFF_DOUT = 4'd8;
  localparam logic [OFF_W-1:0] OFF_SADR = 4'd12;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic              clear;
    logic              fold;
    logic              wordFold;
    logic [WORD_W-1:0] data;
  } crc_strobe_t;

  function automatic logic [5:0] polyWidth(logic [2:0] sel);
    case (sel)
      3'd1:       return 6'd8;
      3'd2, 3'd3: return 6'd16;
      3'd4, 3'd5: return 6'd32;
      default:    return 6'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] polyTaps(logic [2:0] sel);
    case (sel)
      3'd1:    return 32'h0000_0007;
      3'd2:    return 32'h0000_8005;
      3'd3:    return 32'h0000_1021;
      3'd4:    return 32'h04C1_1DB7;
      3'd5:    return 32'h1EDC_6F41;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] widthMask(logic [2:0] sel);
    case (polyWidth(sel))
      6'd8:    return 32'h0000_00FF;
      6'd16:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] mirror(logic [WORD_W-1:0] v, logic [5:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int j = 0; j < WORD_W; j++) begin
      if (j < int'(w)) r[5'(int'(w) - 1 - j)] = v[5'(j)];
    end
    return r;
  endfunction

  // One byte through the selected polynomial, bit-serial unrolled.
  function automatic logic [WORD_W-1:0] foldByte(logic [WORD_W-1:0] st,
                                                 logic [LANE_W-1:0] b,
                                                 logic [2:0] sel,
                                                 logic msbFirst);
    logic [5:0]        w;
    logic [WORD_W-1:0] taps;
    logic [WORD_W-1:0] rtaps;
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] r;
    logic              fb;
    w     = polyWidth(sel);
    taps  = polyTaps(sel);
    rtaps = mirror(taps, w);
    m     = widthMask(sel);
    r     = st & m;
    if (w == 6'd0) return st;
    for (int i = 0; i < LANE_W; i++) begin
      if (msbFirst) begin
        fb = r[5'(w - 6'd1)] ^ b[3'(LANE_W - 1 - i)];
        r  = ((r << 1) & m) ^ (fb ? taps : '0);
      end else begin
        fb = r[0] ^ b[3'(i)];
        r  = (r >> 1) ^ (fb ? rtaps : '0);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_snoop_ctrl.sv
module crc_snoop_ctrl
  import crc_snoop_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SNOOP_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [LANE_W-1:0] busRdIn,
  input  logic [WORD_W-1:0] remainder,
  output logic [WORD_W-1:0] busRdata,
  output crc_strobe_t       strobe,
  output logic [2:0]        polySel,
  output logic              msbFirst
);

  localparam int PAD_SNOOP = WORD_W - SNOOP_W;

  logic               snoopEn;
  logic               snoopOnWrite;
  logic [SNOOP_W-1:0] snoopAddr;
  logic [WORD_W-1:0]  dinReg;
  logic [OFF_W-1:0]   offset;
  logic               regWr;
  logic               regRd;
  logic               snoopHit;
  logic [WORD_W-1:0]  outView;
  logic [WORD_W-1:0]  rdValue;

  assign offset   = busAddr[OFF_W-1:0];
  assign regWr    = busValid && busSel && busWrite;
  assign regRd    = busValid && busSel && !busWrite;
  assign snoopHit = busValid && !busSel && snoopEn && (busWrite == snoopOnWrite)
                    && (busAddr[SNOOP_W-1:0] == snoopAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polySel      <= '0;
      msbFirst     <= 1'b0;
      snoopEn      <= 1'b0;
      snoopOnWrite <= 1'b0;
      snoopAddr    <= '0;
      dinReg       <= '0;
    end else if (regWr) begin
      case (offset)
        OFF_CFG: begin
          polySel  <= busWdata[2:0];
          msbFirst <= busWdata[6];
        end
        OFF_SNP: begin
          snoopEn      <= busWdata[7];
          snoopOnWrite <= busWdata[6];
        end
        OFF_DIN:  dinReg <= (busSize == SIZE_WORD) ? busWdata
                                                   : {{(WORD_W-LANE_W){1'b0}}, busWdata[LANE_W-1:0]};
        OFF_SADR: snoopAddr <= busWdata[SNOOP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clear    = regWr && (offset == OFF_CFG) && busWdata[7];
    strobe.fold     = (regWr && (offset == OFF_DIN)) || snoopHit;
    strobe.wordFold = regWr && (offset == OFF_DIN) && (busSize == SIZE_WORD);
    if (snoopHit)
      strobe.data = {{(WORD_W-LANE_W){1'b0}}, (busWrite ? busWdata[LANE_W-1:0] : busRdIn)};
    else
      strobe.data = busWdata;
  end

  always_comb begin
    outView = remainder & widthMask(polySel);
    case (busSize)
      SIZE_BYTE: outView = {{(WORD_W-8){1'b0}}, outView[7:0]};
      SIZE_HALF: outView = {{(WORD_W-16){1'b0}}, outView[15:0]};
      default: ;
    endcase
    case (offset)
      OFF_CFG:  rdValue = {{(WORD_W-8){1'b0}}, 1'b0, msbFirst, 3'b000, polySel};
      OFF_SNP:  rdValue = {{(WORD_W-8){1'b0}}, snoopEn, snoopOnWrite, 6'b0};
      OFF_DIN:  rdValue = dinReg;
      OFF_DOUT: rdValue = outView;
      OFF_SADR: rdValue = {{PAD_SNOOP{1'b0}}, snoopAddr};
      default:  rdValue = '0;
    endcase
    busRdata = regRd ? rdValue : '0;
  end

endmodule

// File: rtl/crc_snoop_datapath.sv
module crc_snoop_datapath
  import crc_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  crc_strobe_t       strobe,
  input  logic [2:0]        polySel,
  input  logic              msbFirst,
  output logic [WORD_W-1:0] remainder
);

  logic [WORD_W-1:0] stage [LANES+1];
  logic [WORD_W-1:0] nextRem;

  assign stage[0] = remainder;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign stage[k+1] = foldByte(stage[k], strobe.data[k*LANE_W +: LANE_W], polySel, msbFirst);
  end

  assign nextRem = strobe.wordFold ? stage[LANES] : stage[1];

  always_ff @(posedge clk) begin
    if (!rstN)             remainder <= '0;
    else if (strobe.clear) remainder <= '0;
    else if (strobe.fold)  remainder <= nextRem;
  end

endmodule

// File: rtl/crc_snoop_unit.sv
module crc_snoop_unit
  import crc_snoop_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SNOOP_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [7:0]        busRdIn,
  output logic [31:0]       busRdata
);

  crc_strobe_t       strobe;
  logic [2:0]        polySel;
  logic              msbFirst;
  logic [WORD_W-1:0] remainder;

  crc_snoop_ctrl #(.ADDR_W(ADDR_W), .SNOOP_W(SNOOP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdIn(busRdIn), .remainder(remainder),
    .busRdata(busRdata), .strobe(strobe), .polySel(polySel), .msbFirst(msbFirst)
  );

  crc_snoop_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polySel(polySel),
    .msbFirst(msbFirst), .remainder(remainder)
  );

endmodule

// File: rtl/crc_snoop_checks.sv
module crc_snoop_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [2:0]        polySel,
  input logic [31:0]       remainder
);

  logic cfgClear;
  logic polyOff;
  logic outRead;
  assign cfgClear = busValid && busSel && busWrite && (busAddr[3:0] == 4'd0) && busWdata[7];
  assign polyOff  = (polySel == 3'd0) || (polySel > 3'd5);
  assign outRead  = busValid && busSel && !busWrite && (busAddr[3:0] == 4'd8);

  a_r8_reset_clears: assert property (@(posedge clk) !rstN |=> remainder == 32'd0);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |=> remainder == 32'd0);

  a_r3_bit7_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSel && !busWrite && busAddr[3:0] == 4'd0) |-> !busRdata[7]);

  a_r1_off_holds: assert property (@(posedge clk) disable iff (!rstN)
    (polyOff && !cfgClear) |=> $stable(remainder));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> $stable(remainder));

  a_r10_crc8_upper: assert property (@(posedge clk) disable iff (!rstN)
    (outRead && polySel == 3'd1) |-> busRdata[31:8] == 24'd0);

  a_r10_crc16_upper: assert property (@(posedge clk) disable iff (!rstN)
    (outRead && (polySel == 3'd2 || polySel == 3'd3)) |-> busRdata[31:16] == 16'd0);

endmodule

bind crc_snoop_unit crc_snoop_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .polySel(polySel), .remainder(remainder)
);

// File: tb/sim_crc_snoop_unit.sv
`timescale 1ns/1ps
module sim_crc_snoop_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [15:0] busAddr = 16'd0;
  logic [31:0] busWdata = 32'd0;
  logic [7:0]  busRdIn = 8'd0;
  logic [31:0] busRdata;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [2:0]  mPoly = 3'd0;
  logic        mMsb = 1'b0;
  logic [31:0] mRem = 32'd0;

  always #5 clk = ~clk;

  crc_snoop_unit u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdIn(busRdIn), .busRdata(busRdata)
  );

  function automatic int mWidth(logic [2:0] p);
    if (p == 3'd1) return 8;
    if (p == 3'd2 || p == 3'd3) return 16;
    if (p == 3'd4 || p == 3'd5) return 32;
    return 0;
  endfunction

  function automatic logic [31:0] mTaps(logic [2:0] p);
    logic [31:0] t [6] = '{32'h0, 32'h07, 32'h8005, 32'h1021, 32'h04C11DB7, 32'h1EDC6F41};
    return (p <= 3'd5) ? t[p] : 32'h0;
  endfunction

  function automatic logic [31:0] mRefl(logic [31:0] v, int w);
    logic [31:0] r = 32'h0;
    for (int i = 0; i < w; i++) r[w-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mMsbFold(logic [31:0] r, logic [7:0] b, logic [31:0] t, int w);
    logic [31:0] msk = (w == 32) ? 32'hFFFFFFFF : ((32'h1 << w) - 1);
    for (int k = 7; k >= 0; k--) begin
      logic top = r[w-1] ^ b[k];
      r = (r << 1) & msk;
      if (top) r = r ^ t;
    end
    return r;
  endfunction

  // LSB-first is computed as the mirror of an MSB-first pass over mirrored data.
  function automatic logic [31:0] mStep(logic [31:0] r, logic [7:0] b, logic [2:0] p, logic msb);
    int w = mWidth(p);
    if (w == 0) return r;
    if (msb) return mMsbFold(r, b, mTaps(p), w);
    return mRefl(mMsbFold(mRefl(r, w), mRefl({24'h0, b}, 8)[7:0], mTaps(p), w), w);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic sel, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busSel = sel; busWrite = 1'b1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic sel, input logic [15:0] a, input logic [1:0] sz,
                       input logic [7:0] rdIn, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busSel = sel; busWrite = 1'b0; busAddr = a; busSize = sz; busRdIn = rdIn;
    #1 d = busRdata;
    @(negedge clk);
    busValid = 1'b0; busSel = 1'b0;
  endtask

  task automatic setCfg(input logic [2:0] p, input logic msb, input logic clr);
    busWr(1'b1, 16'd0, 2'd0, {24'h0, clr, msb, 3'b000, p});
    mPoly = p; mMsb = msb;
    if (clr) mRem = 32'h0;
  endtask

  task automatic feedByte(input logic [7:0] b);
    busWr(1'b1, 16'd4, 2'd0, {24'hFFFFFF, b});
    mRem = mStep(mRem, b, mPoly, mMsb);
  endtask

  task automatic checkOut(input string req);
    logic [31:0] d;
    busRd(1'b1, 16'd8, 2'd2, 8'h00, d);
    check(req, d, mRem);
  endtask

  string digits = "123456789";

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset values
    busRd(1'b1, 16'd0,  2'd0, 8'h00, d); check("R8 cfg", d, 32'h0);
    busRd(1'b1, 16'd1,  2'd0, 8'h00, d); check("R8 snoopctl", d, 32'h0);
    busRd(1'b1, 16'd8,  2'd2, 8'h00, d); check("R8 out", d, 32'h0);
    busRd(1'b1, 16'd12, 2'd2, 8'h00, d); check("R8 snoopaddr", d, 32'h0);

    // R1 R2 R5: every polynomial and both orders over the check string
    for (int p = 1; p <= 5; p++) begin
      for (int o = 0; o < 2; o++) begin
        setCfg(3'(p), 1'(o), 1'b1);
        for (int i = 0; i < digits.len(); i++) begin
          feedByte(digits[i]);
          checkOut("R1 R2 R5 byte fold");
        end
        if (p == 2 && o == 0) check("R1 crc16 lsb known", mRem, 32'h0000BB3D);
        if (p == 3 && o == 1) check("R1 ccitt msb known", mRem, 32'h000031C3);
        if (p == 3 && o == 0) check("R2 ccitt lsb known", mRem, 32'h00002189);
        if (p == 1 && o == 1) check("R1 crc8 msb known", mRem, 32'h000000F4);
        // R10: narrow results leave upper bits zero
        if (p <= 3) begin
          busRd(1'b1, 16'd8, 2'd2, 8'h00, d);
          check("R10 upper zero", d & ((p == 1) ? 32'hFFFFFF00 : 32'hFFFF0000), 32'h0);
        end
      end
    end

    // R3: bit7 reads zero, writing 0 in bit7 keeps the remainder
    setCfg(3'd4, 1'b0, 1'b1);
    feedByte(8'hA5);
    setCfg(3'd4, 1'b0, 1'b0);
    checkOut("R3 no clear when bit7 is 0");
    busRd(1'b1, 16'd0, 2'd0, 8'h00, d); check("R3 cfg readback bit7 zero", d, 32'h04);
    setCfg(3'd4, 1'b1, 1'b1);
    checkOut("R3 clear");
    busRd(1'b1, 16'd0, 2'd0, 8'h00, d); check("R2 cfg readback order bit", d, 32'h44);

    // R5: word writes fold four bytes LSB first
    setCfg(3'd4, 1'b0, 1'b1);
    busWr(1'b1, 16'd4, 2'd2, 32'h04030201);
    mRem = mStep(mStep(mStep(mStep(mRem, 8'h01, mPoly, mMsb), 8'h02, mPoly, mMsb), 8'h03, mPoly, mMsb), 8'h04, mPoly, mMsb);
    checkOut("R5 word crc32 lsb");
    busRd(1'b1, 16'd4, 2'd2, 8'h00, d); check("R5 input readback", d, 32'h04030201);
    setCfg(3'd3, 1'b1, 1'b1);
    busWr(1'b1, 16'd4, 2'd2, 32'hDEADBEEF);
    mRem = mStep(mStep(mStep(mStep(mRem, 8'hEF, mPoly, mMsb), 8'hBE, mPoly, mMsb), 8'hAD, mPoly, mMsb), 8'hDE, mPoly, mMsb);
    checkOut("R5 word ccitt msb");
    busWr(1'b1, 16'd4, 2'd1, 32'h00001234);
    mRem = mStep(mRem, 8'h34, mPoly, mMsb);
    checkOut("R5 half size folds one byte");

    // R6: narrow views
    setCfg(3'd5, 1'b1, 1'b1);
    feedByte(8'h31); feedByte(8'h7E);
    busRd(1'b1, 16'd8, 2'd0, 8'h00, d); check("R6 byte view", d, {24'h0, mRem[7:0]});
    busRd(1'b1, 16'd8, 2'd1, 8'h00, d); check("R6 half view", d, {16'h0, mRem[15:0]});
    busRd(1'b1, 16'd8, 2'd2, 8'h00, d); check("R6 word view", d, mRem);

    // R1: invalid codes leave the remainder unchanged
    for (int p = 0; p < 8; p += 6) begin
      setCfg(3'(p), 1'b0, 1'b0);
      busWr(1'b1, 16'd4, 2'd2, 32'h11223344);
      checkOut("R1 disabled code holds");
    end
    setCfg(3'd7, 1'b0, 1'b0);
    busWr(1'b1, 16'd4, 2'd0, 32'h55);
    checkOut("R1 code 7 holds");

    // R7: snoop address width
    busWr(1'b1, 16'd12, 2'd1, 32'h0000FFFF);
    busRd(1'b1, 16'd12, 2'd1, 8'h00, d); check("R7 snoop addr 14 bits", d, 32'h3FFF);
    busWr(1'b1, 16'd12, 2'd1, 32'h00001234);

    // R4 R9: snoop on write
    setCfg(3'd4, 1'b1, 1'b1);
    busWr(1'b1, 16'd1, 2'd0, 32'hC0);
    busRd(1'b1, 16'd1, 2'd0, 8'h00, d); check("R4 snoopctl readback", d, 32'hC0);
    busWr(1'b0, 16'h1234, 2'd0, 32'h000000AB);
    mRem = mStep(mRem, 8'hAB, mPoly, mMsb);
    checkOut("R9 snoop write hit");
    busWr(1'b0, 16'h5234, 2'd0, 32'h0000003C);
    mRem = mStep(mRem, 8'h3C, mPoly, mMsb);
    checkOut("R9 snoop high bits ignored");
    busWr(1'b0, 16'h1235, 2'd0, 32'h00000077);
    checkOut("R9 address miss ignored");
    busRd(1'b0, 16'h1234, 2'd0, 8'h99, d);
    checkOut("R9 wrong direction ignored");

    // R4 R9: snoop on read
    busWr(1'b1, 16'd1, 2'd0, 32'h80);
    busRd(1'b0, 16'h1234, 2'd0, 8'h5A, d);
    mRem = mStep(mRem, 8'h5A, mPoly, mMsb);
    checkOut("R9 snoop read hit");
    busWr(1'b0, 16'h1234, 2'd0, 32'h00000011);
    checkOut("R4 read mode ignores writes");

    // R4: disabled snoop
    busWr(1'b1, 16'd1, 2'd0, 32'h40);
    busWr(1'b0, 16'h1234, 2'd0, 32'h00000022);
    checkOut("R4 snoop disabled");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule